// File: doc/BRIEF.md
# Byte-Lane Pseudo-SRAM Model

This block is a clocked, synthesizable model of a 16-bit memory with an asynchronous-SRAM style control set. It is meant to sit opposite a memory controller as the device under test. The controller drives active-low chip select, power-down, output enable, write enable and two byte strobes, plus a 21-bit address and write data. The model returns read data together with a per-lane drive flag, which replaces a real tri-state bus. Only the low `DEPTH_W` address bits index the array, so the model stays small in simulation.

Each clock the control pins are decoded into one mode. Power-down outranks every other pin. Reads come straight from the array, one byte lane at a time. A write is held pending while the write overlap lasts. It is committed on the clock where the overlap ends, using the address, data and strobes from its last cycle. Power-down wipes the validity of every word. The model then refuses access until a wake-up condition has been met: two completed read cycles, or a run of consecutive standby cycles.

Top module: `lane_psram_model`

## Requirements
- R1: While `pd_ni` is low, both bits of `lane_oe_o` are 0 whatever the other inputs are, `ready_o` is 0 from the next clock, and every word becomes invalid.
- R2: With `pd_ni` high and `cs_ni` high, both lanes are undriven and stored words are kept for any number of cycles.
- R3: With `cs_ni` low and both strobes high, both lanes are undriven and a write attempt changes no word.
- R4: With `cs_ni` low, `we_ni` high, `oe_ni` high and at least one strobe low, both lanes are undriven.
- R5: A read (ready, `cs_ni`=0, `oe_ni`=0, `we_ni`=1) sets `lane_oe_o[0]` = !`lb_ni` for bits 7:0 and `lane_oe_o[1]` = !`ub_ni` for bits 15:8. The addressed word appears on driven lanes, and undriven lanes show 0.
- R6: A write (ready, `cs_ni`=0, `we_ni`=0) ignores `oe_ni` and updates only the lanes whose strobe is low. The other lane keeps its value.
- R7: A write that spans several cycles commits once, on the clock where `cs_ni` or `we_ni` rises. It uses the address, data and strobes of its last cycle, and addresses seen earlier in the overlap are not written.
- R8: After reset or power-down, a read of a word not yet written raises `rd_invalid_o` with `rdata_o` = 0. Writing the word clears the flag for that word.
- R9: `ready_o` is 0 after reset and after power-down. While it is 0 no lane is driven and writes are dropped. Once it is 1 it stays 1 until power-down.
- R10: While not ready, `ready_o` rises on the clock where a second read cycle ends. A read cycle ends when the read mode is left.
- R11: While not ready, `ready_o` rises at the end of the `WAKE_CYC`-th consecutive standby cycle (`pd_ni`=1, `cs_ni`=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Model clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| pd_ni | input | 1 | Power-down request, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| lb_ni | input | 1 | Strobe for bits 7:0, active low |
| ub_ni | input | 1 | Strobe for bits 15:8, active low |
| addr_i | input | 21 | Word address (low DEPTH_W bits used) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, zero on undriven lanes |
| lane_oe_o | output | 2 | Per-lane drive flag; bit 0 for bits 7:0 |
| rd_invalid_o | output | 1 | Read of a word that holds no valid data |
| ready_o | output | 1 | Wake-up complete, normal access allowed |

## Verification
The array is filled with an arithmetic word pattern. Every word is then read under all four strobe combinations, which separates a lane swap, a missing lane mask and a deselect leak. A second pass of alternating single-lane writes, some with output enable low, shows that the unwritten lane is kept and that output enable has no effect on writes. A multi-cycle write that changes address mid-overlap and ends on a chip-select rise tells a last-cycle commit from an early one. The wake-up paths are tried separately: one read, then two reads after reset, and a standby run one cycle short of and exactly equal to the timeout after power-down. After that power-down a full sweep checks that every word is flagged invalid.

// File: rtl/psram_pkg.sv
package psram_pkg;
  typedef enum logic [2:0] {
    MD_PD,
    MD_STBY,
    MD_DESEL,
    MD_OUTDIS,
    MD_READ,
    MD_WRITE
  } mode_e;
endpackage

// File: rtl/psram_mode_dec.sv
module psram_mode_dec
  import psram_pkg::*;
(
  input  logic       cs_ni,
  input  logic       pd_ni,
  input  logic       oe_ni,
  input  logic       we_ni,
  input  logic [1:0] byte_ni,
  output mode_e      mode_o
);
  // priority: power-down, chip select, strobes, write, output enable
  always_comb begin
    if (!pd_ni)             mode_o = MD_PD;
    else if (cs_ni)         mode_o = MD_STBY;
    else if (&byte_ni)      mode_o = MD_DESEL;
    else if (!we_ni)        mode_o = MD_WRITE;
    else if (oe_ni)         mode_o = MD_OUTDIS;
    else                    mode_o = MD_READ;
  end
endmodule

// File: rtl/psram_wake.sv
module psram_wake
  import psram_pkg::*;
#(
  parameter int WAKE_CYC = 8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  output logic  ready_o
);
  localparam int CNT_W = $clog2(WAKE_CYC + 1);

  logic             ready_q;
  logic             rd_q;
  logic             rd_cnt_q;
  logic [CNT_W-1:0] stby_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q    <= 1'b0;
      rd_q       <= 1'b0;
      rd_cnt_q   <= 1'b0;
      stby_cnt_q <= '0;
    end else if (mode_i == MD_PD) begin
      ready_q    <= 1'b0;
      rd_q       <= 1'b0;
      rd_cnt_q   <= 1'b0;
      stby_cnt_q <= '0;
    end else begin
      rd_q <= (mode_i == MD_READ);
      if (!ready_q) begin
        // read cycle ends when read mode is left
        if (rd_q && mode_i != MD_READ) begin
          if (rd_cnt_q) ready_q <= 1'b1;
          rd_cnt_q <= 1'b1;
        end
        if (mode_i == MD_STBY) begin
          if (stby_cnt_q == CNT_W'(WAKE_CYC - 1)) ready_q <= 1'b1;
          else stby_cnt_q <= stby_cnt_q + 1'b1;
        end else begin
          stby_cnt_q <= '0;
        end
      end
    end
  end

  assign ready_o = ready_q;

  AST_READY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_q && mode_i != MD_PD) |=> ready_q); // R9
  AST_PD_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MD_PD) |=> !ready_q); // R1
endmodule

// File: rtl/psram_array.sv
module psram_array #(
  parameter int LANE_W    = 8,
  parameter int NUM_LANES = 2,
  parameter int DEPTH_W   = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wipe_i,
  input  logic                          capture_i,
  input  logic [DEPTH_W-1:0]            wr_idx_i,
  input  logic [NUM_LANES*LANE_W-1:0]   wdata_i,
  input  logic [NUM_LANES-1:0]          lane_we_i,
  input  logic [DEPTH_W-1:0]            rd_idx_i,
  output logic [NUM_LANES*LANE_W-1:0]   rd_word_o,
  output logic                          rd_valid_o
);
  localparam int DEPTH  = 1 << DEPTH_W;
  localparam int DATA_W = NUM_LANES * LANE_W;

  logic                 pend_q;
  logic [DEPTH_W-1:0]   pa_q;
  logic [DATA_W-1:0]    pdat_q;
  logic [NUM_LANES-1:0] pm_q;
  logic [DEPTH-1:0]     valid_q;
  logic                 commit;

  // pending write commits on the first clock after the overlap
  assign commit = pend_q && !capture_i && !wipe_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      pa_q    <= '0;
      pdat_q  <= '0;
      pm_q    <= '0;
      valid_q <= '0;
    end else if (wipe_i) begin
      pend_q  <= 1'b0;
      valid_q <= '0;
    end else if (capture_i) begin
      pend_q <= 1'b1;
      pa_q   <= wr_idx_i;
      pdat_q <= wdata_i;
      pm_q   <= lane_we_i;
    end else if (pend_q) begin
      pend_q        <= 1'b0;
      valid_q[pa_q] <= |pm_q;
    end
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];
    always_ff @(posedge clk_i) begin
      if (commit && pm_q[l]) mem_q[pa_q] <= pdat_q[l*LANE_W +: LANE_W];
    end
    assign rd_word_o[l*LANE_W +: LANE_W] = mem_q[rd_idx_i];
  end

  assign rd_valid_o = valid_q[rd_idx_i];

  AST_WIPE_INVALIDATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wipe_i |=> (valid_q == '0)); // R8
  AST_COMMIT_MARKS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> valid_q[$past(pa_q)]); // R7
endmodule

// File: rtl/lane_psram_model.sv
module lane_psram_model
  import psram_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int LANE_W   = 8,
  parameter int DEPTH_W  = 4,
  parameter int WAKE_CYC = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cs_ni,
  input  logic                   pd_ni,
  input  logic                   oe_ni,
  input  logic                   we_ni,
  input  logic                   lb_ni,
  input  logic                   ub_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [2*LANE_W-1:0]    wdata_i,
  output logic [2*LANE_W-1:0]    rdata_o,
  output logic [1:0]             lane_oe_o,
  output logic                   rd_invalid_o,
  output logic                   ready_o
);
  localparam int NUM_LANES = 2;
  localparam int DATA_W    = NUM_LANES * LANE_W;

  mode_e                mode;
  logic [1:0]           byte_n;
  logic                 ready;
  logic [DATA_W-1:0]    rd_word;
  logic                 rd_valid;
  logic                 rd_ok;
  logic                 unused_addr;

  assign byte_n      = {ub_ni, lb_ni};
  assign unused_addr = ^addr_i[ADDR_W-1:DEPTH_W];

  psram_mode_dec i_dec (
    .cs_ni   (cs_ni),
    .pd_ni   (pd_ni),
    .oe_ni   (oe_ni),
    .we_ni   (we_ni),
    .byte_ni (byte_n),
    .mode_o  (mode)
  );

  psram_wake #(.WAKE_CYC(WAKE_CYC)) i_wake (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .ready_o (ready)
  );

  psram_array #(
    .LANE_W    (LANE_W),
    .NUM_LANES (NUM_LANES),
    .DEPTH_W   (DEPTH_W)
  ) i_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wipe_i     (mode == MD_PD),
    .capture_i  (mode == MD_WRITE && ready),
    .wr_idx_i   (addr_i[DEPTH_W-1:0]),
    .wdata_i    (wdata_i),
    .lane_we_i  (~byte_n),
    .rd_idx_i   (addr_i[DEPTH_W-1:0]),
    .rd_word_o  (rd_word),
    .rd_valid_o (rd_valid)
  );

  assign rd_ok        = (mode == MD_READ) && ready;
  assign lane_oe_o    = rd_ok ? ~byte_n : 2'b00;
  assign rd_invalid_o = rd_ok && !rd_valid;
  assign ready_o      = ready;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_out
    assign rdata_o[l*LANE_W +: LANE_W] =
      (lane_oe_o[l] && rd_valid) ? rd_word[l*LANE_W +: LANE_W] : '0;
  end

  AST_PD_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |-> (lane_oe_o == 2'b00)); // R1
  AST_LANE_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_oe_o != 2'b00) |-> (!cs_ni && !oe_ni && we_ni && pd_ni && ready_o)); // R5
  AST_INVALID_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_invalid_o |-> (rdata_o == '0)); // R8
  AST_NOT_READY_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> (lane_oe_o == 2'b00)); // R9
endmodule

// File: tb/test_lane_psram_model.sv
module test_lane_psram_model;
  localparam int DEPTH = 16;
  localparam int WAKE  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs, pd, oe, we, lb, ub;
  logic [20:0] addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [1:0]  lane_oe;
  logic        rd_inv, ready;

  int checks = 0;
  int fails  = 0;
  logic done = 1'b0;

  logic [15:0] exp_mem [DEPTH];
  logic        exp_val [DEPTH];
  logic        exp_rdy = 1'b0;

  always #10 clk = ~clk;

  lane_psram_model #(.DEPTH_W(4), .WAKE_CYC(WAKE)) i_lane_psram_model (
    .clk_i (clk), .rst_ni (rst_n), .cs_ni (cs), .pd_ni (pd), .oe_ni (oe),
    .we_ni (we), .lb_ni (lb), .ub_ni (ub), .addr_i (addr), .wdata_i (wdata),
    .rdata_o (rdata), .lane_oe_o (lane_oe), .rd_invalid_o (rd_inv),
    .ready_o (ready)
  );

  function automatic logic [15:0] pat_a(int a);
    return 16'(a * 16'h1357) ^ 16'hA5C3;
  endfunction
  function automatic logic [15:0] pat_b(int a);
    return 16'(a * 16'h0B1D) ^ 16'h3C69;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs = 1; pd = 1; oe = 1; we = 1; lb = 1; ub = 1;
  endtask

  task automatic rd_chk(input int a, input logic l, input logic u, input string req);
    logic [1:0]  e_oe;
    logic [15:0] e_dat;
    logic        e_inv;
    @(negedge clk);
    cs = 0; pd = 1; oe = 0; we = 1; lb = l; ub = u; addr = 21'(a);
    #2;
    e_oe  = (exp_rdy && !(l && u)) ? {~u, ~l} : 2'b00;
    e_inv = (e_oe != 2'b00) && !exp_val[a];
    e_dat = (e_oe != 2'b00 && exp_val[a]) ?
            (exp_mem[a] & {{8{e_oe[1]}}, {8{e_oe[0]}}}) : 16'h0000;
    chk({req, " lane_oe"}, 32'(lane_oe), 32'(e_oe));
    chk({req, " rdata"},   32'(rdata),   32'(e_dat));
    chk({req, " invalid"}, 32'(rd_inv),  32'(e_inv));
    @(negedge clk);
    idle();
  endtask

  task automatic wr(input int a, input logic [15:0] d, input logic l, input logic u, input logic o);
    @(negedge clk);
    cs = 0; pd = 1; we = 0; oe = o; lb = l; ub = u; addr = 21'(a); wdata = d;
    @(negedge clk);
    idle();
    if (exp_rdy && !(l && u)) begin
      if (!l) exp_mem[a][7:0]  = d[7:0];
      if (!u) exp_mem[a][15:8] = d[15:8];
      exp_val[a] = 1'b1;
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle();
    addr = '0; wdata = '0;
    for (int i = 0; i < DEPTH; i++) begin
      exp_mem[i] = '0;
      exp_val[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk("R9 ready in reset", 32'(ready), 0);
    chk("R9 lanes in reset", 32'(lane_oe), 0);
    rst_n = 1;

    // R10: wake by two reads; R9: no access before ready
    rd_chk(0, 0, 0, "R9 read before ready");
    @(negedge clk);
    chk("R10 one read not enough", 32'(ready), 0);
    wr(5, 16'h1234, 0, 0, 1);
    rd_chk(1, 0, 0, "R9 second read before ready");
    @(negedge clk);
    chk("R10 ready after two reads", 32'(ready), 1);
    exp_rdy = 1'b1;
    rd_chk(5, 0, 0, "R9 write dropped, R8 invalid");

    // R5/R3: word fill, all strobe combinations
    for (int a = 0; a < DEPTH; a++) wr(a, pat_a(a), 0, 0, 1);
    for (int a = 0; a < DEPTH; a++)
      for (int s = 0; s < 4; s++)
        rd_chk(a, s[0], s[1], "R5 R3 strobe sweep");

    // R6: single-lane writes, oe low on even addresses
    for (int a = 0; a < DEPTH; a++)
      wr(a, pat_b(a), a[0], !a[0], a[0]);
    for (int a = 0; a < DEPTH; a++) rd_chk(a, 0, 0, "R6 lane kept");

    // R3: write with both strobes high
    wr(2, 16'hFFFF, 1, 1, 1);
    rd_chk(2, 0, 0, "R3 deselect write");

    // R4: output disabled
    @(negedge clk);
    cs = 0; oe = 1; we = 1; lb = 0; ub = 0; addr = 21'(3);
    #2 chk("R4 output disabled", 32'(lane_oe), 0);
    @(negedge clk); idle();

    // R7: multi-cycle write, address moves, ends on cs rise
    @(negedge clk);
    cs = 0; we = 0; oe = 1; lb = 0; ub = 0; addr = 21'(7); wdata = 16'hAAAA;
    @(negedge clk);
    addr = 21'(9); wdata = 16'h5555;
    @(negedge clk);
    cs = 1;
    @(negedge clk);
    idle();
    exp_mem[9] = 16'h5555;
    rd_chk(7, 0, 0, "R7 early address untouched");
    rd_chk(9, 0, 0, "R7 last cycle committed");

    // R2: long standby retention
    repeat (30) @(negedge clk);
    for (int a = 0; a < DEPTH; a++) rd_chk(a, 0, 0, "R2 retained");

    // R1: power-down overrides a read
    @(negedge clk);
    pd = 0; cs = 0; oe = 0; we = 1; lb = 0; ub = 0; addr = 21'(1);
    #2 chk("R1 lanes off in power-down", 32'(lane_oe), 0);
    @(negedge clk);
    chk("R1 ready dropped", 32'(ready), 0);
    exp_rdy = 1'b0;
    for (int i = 0; i < DEPTH; i++) exp_val[i] = 1'b0;
    repeat (2) @(negedge clk);

    // R11: standby timeout wake
    idle();
    repeat (WAKE - 1) @(negedge clk);
    chk("R11 one cycle short", 32'(ready), 0);
    @(negedge clk);
    chk("R11 timeout reached", 32'(ready), 1);
    exp_rdy = 1'b1;

    // R8: everything invalid after power-down
    for (int a = 0; a < DEPTH; a++) rd_chk(a, 0, 0, "R8 invalid after power-down");
    wr(4, 16'hBEEF, 0, 0, 1);
    rd_chk(4, 0, 0, "R8 valid after rewrite");
    rd_chk(4, 1, 0, "R8 R5 upper lane only");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule